// File: doc/BRIEF.md
# Secondary Timebase Counter with Gated Accumulation

This block is a 24-bit time counter for channel timing. Its count can advance from one of several sources. The first is a synchronised external clock pin. The second is a fixed divide-by-eight of the system clock. The third is that same divided clock, counted only while a synchronised gate input is high, which turns the counter into a pulse accumulator. A shared programmable prescaler sits after whichever of these sources is selected. The fourth mode is angle mode. In angle mode the count advances directly on an increment input, with no prescaling.

Engines read the count and may overwrite it at any time. The host has a read-only copy of the count. A value arriving on the shared time bus can be imported into the counter, except in angle mode. In angle mode any import request is refused.

Top module: `sec_timebase`

## Requirements
- R1: After reset the count is 0.
- R2: An engine write loads `engWrData` into the count at the next clock edge and wins over every other update. It also restarts the prescaler phase and the divide-by-eight phase.
- R3: `engRdData` and `hostRdData` both show the current count at all times.
- R4: With mode 2'b00 the count rises by one for every N+1 rising edges of `extClk`, where N is `preRatio`. The pin passes through a two-flop synchroniser before use.
- R5: With mode 2'b01 the first increment after an engine write comes 8*(N+1) clocks after the write edge. The count then rises by one every 8*(N+1) clocks.
- R6: With mode 2'b10 the count behaves as in mode 2'b01 while `gateIn`, after two synchronising flops, is high. While the gate is low the count holds.
- R7: With mode 2'b11 each cycle with `angleInc` high adds one at the next edge, and no prescaler is applied. In every other mode `angleInc` has no effect.
- R8: In modes other than 2'b11, `importReq` loads `importData` at the next edge, unless an engine write happens in the same cycle.
- R9: In mode 2'b11, `importReq` is ignored and the count keeps its value.
- R10: The count wraps from 24'hFFFFFF to 0.
- R11: Without a write or an import, the count changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Count source: 00 ext pin, 01 sysclk/8, 10 gated sysclk/8, 11 angle |
| preRatio | input | 6 | Prescaler field; divide ratio is value+1 |
| extClk | input | 1 | External clock pin (asynchronous) |
| gateIn | input | 1 | Accumulator gate (asynchronous) |
| angleInc | input | 1 | Unprescaled increment used in angle mode |
| engWrEn | input | 1 | Engine write strobe |
| engWrData | input | 24 | Engine write value |
| importReq | input | 1 | Shared-bus import request |
| importData | input | 24 | Shared-bus import value |
| engRdData | output | 24 | Engine read of the count |
| hostRdData | output | 24 | Host read-only view of the count |

## Verification
The assertions assume three things about the inputs. `mode` and `preRatio` only change while the count is otherwise idle. Write and import strobes are sampled at clock edges. `angleInc` is a plain per-cycle request.

The stimulus follows these assumptions. It drives every input at the falling clock edge. It changes the configuration only just before an engine write, which restarts both dividers. It keeps `extClk` low, and holds `gateIn` at its level, for several cycles around each such write. Expected counts then follow from the tick arithmetic alone.

// File: rtl/sec_timebase_pkg.sv
package sec_timebase_pkg;
  typedef enum logic [1:0] {
    SRC_EXT   = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_GATED = 2'b10,
    SRC_ANGLE = 2'b11
  } srcMode_e;

  typedef struct packed {
    logic wrLoad;
    logic impLoad;
    logic inc;
  } tbStrobe_t;
endpackage

// File: rtl/sec_timebase_ctrl.sv
module sec_timebase_ctrl
  import sec_timebase_pkg::*;
#(
  parameter int RATIO_W     = 6,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic [RATIO_W-1:0] preRatio,
  input  logic               extClk,
  input  logic               gateIn,
  input  logic               angleInc,
  input  logic               engWrEn,
  input  logic               importReq,
  output tbStrobe_t          strobe
);
  localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

  logic [SYNC_STAGES:0]   extSh;
  logic [SYNC_STAGES-1:0] gateSh;
  logic [DIV_W-1:0]       divCnt;
  logic [RATIO_W-1:0]     preCnt;
  logic                   extEdge, gateOk, divTick, srcTick, preDone, isAngle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSh  <= '0;
      gateSh <= '0;
    end else begin
      extSh  <= {extSh[SYNC_STAGES-1:0], extClk};
      gateSh <= {gateSh[SYNC_STAGES-2:0], gateIn};
    end
  end

  assign extEdge = extSh[SYNC_STAGES-1] & ~extSh[SYNC_STAGES];
  assign gateOk  = gateSh[SYNC_STAGES-1];
  assign divTick = (divCnt == DIV_LAST);
  assign isAngle = (srcMode_e'(mode) == SRC_ANGLE);

  always_comb begin
    unique case (srcMode_e'(mode))
      SRC_EXT:   srcTick = extEdge;
      SRC_DIV8:  srcTick = divTick;
      SRC_GATED: srcTick = divTick & gateOk;
      default:   srcTick = 1'b0;
    endcase
  end

  assign preDone = srcTick && (preCnt == preRatio);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      preCnt <= '0;
    end else if (engWrEn) begin
      divCnt <= '0;
      preCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (srcTick) preCnt <= preDone ? '0 : preCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.wrLoad  = engWrEn;
    strobe.impLoad = importReq && !isAngle && !engWrEn;
    strobe.inc     = (isAngle ? angleInc : preDone) && !engWrEn && !strobe.impLoad;
  end
endmodule

// File: rtl/sec_timebase_dp.sv
module sec_timebase_dp
  import sec_timebase_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] impData,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.wrLoad)  count <= wrData;
    else if (strobe.impLoad) count <= impData;
    else if (strobe.inc)     count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/sec_timebase.sv
module sec_timebase
  import sec_timebase_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int RATIO_W     = 6,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic [RATIO_W-1:0] preRatio,
  input  logic               extClk,
  input  logic               gateIn,
  input  logic               angleInc,
  input  logic               engWrEn,
  input  logic [CNT_W-1:0]   engWrData,
  input  logic               importReq,
  input  logic [CNT_W-1:0]   importData,
  output logic [CNT_W-1:0]   engRdData,
  output logic [CNT_W-1:0]   hostRdData
);
  tbStrobe_t        strobe;
  logic [CNT_W-1:0] count;

  sec_timebase_ctrl #(
    .RATIO_W(RATIO_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .preRatio(preRatio),
    .extClk(extClk), .gateIn(gateIn), .angleInc(angleInc),
    .engWrEn(engWrEn), .importReq(importReq), .strobe(strobe)
  );

  sec_timebase_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(engWrData), .impData(importData), .count(count)
  );

  assign engRdData  = count;
  assign hostRdData = count;
endmodule

// File: rtl/sec_timebase_chk.sv
module sec_timebase_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             angleInc,
  input logic             engWrEn,
  input logic [CNT_W-1:0] engWrData,
  input logic             importReq,
  input logic [CNT_W-1:0] importData,
  input logic [CNT_W-1:0] engRdData,
  input logic [CNT_W-1:0] hostRdData
);
  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    engWrEn |=> engRdData == $past(engWrData));

  assert_same_view_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostRdData == engRdData);

  assert_angle_inc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && angleInc && !engWrEn) |=> engRdData == $past(engRdData) + CNT_W'(1));

  assert_import_loads_R8: assert property (@(posedge clk) disable iff (!rstN)
    (importReq && !engWrEn && mode != 2'b11) |=> engRdData == $past(importData));

  assert_angle_no_import_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && importReq && !engWrEn && !angleInc) |=> $stable(engRdData));

  assert_single_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!engWrEn && !importReq) |=>
      (engRdData == $past(engRdData) || engRdData == $past(engRdData) + CNT_W'(1)));
endmodule

bind sec_timebase sec_timebase_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .angleInc(angleInc),
  .engWrEn(engWrEn), .engWrData(engWrData), .importReq(importReq),
  .importData(importData), .engRdData(engRdData), .hostRdData(hostRdData)
);

// File: tb/test_sec_timebase.sv
`timescale 1ns/1ps
module test_sec_timebase;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [5:0]  preRatio = '0;
  logic        extClk = 1'b0, gateIn = 1'b0, angleInc = 1'b0;
  logic        engWrEn = 1'b0, importReq = 1'b0;
  logic [23:0] engWrData = '0, importData = '0;
  logic [23:0] engRdData, hostRdData;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sec_timebase i_sec_timebase (
    .clk(clk), .rstN(rstN), .mode(mode), .preRatio(preRatio),
    .extClk(extClk), .gateIn(gateIn), .angleInc(angleInc),
    .engWrEn(engWrEn), .engWrData(engWrData), .importReq(importReq),
    .importData(importData), .engRdData(engRdData), .hostRdData(hostRdData)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic engWrite(input logic [23:0] v);
    @(negedge clk);
    engWrEn = 1'b1; engWrData = v;
    @(negedge clk);
    engWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 reset count", engRdData, 24'h0);
    rstN = 1'b1;
    idle(2);
    chk("R1 after release", hostRdData, 24'h0);

    // R2, R3: write and read views
    engWrite(24'hA5C3E1);
    chk("R2 engine write", engRdData, 24'hA5C3E1);
    chk("R3 host view", hostRdData, 24'hA5C3E1);

    // R5: sysclk/8 prescaled sweep
    mode = 2'b01;
    for (int n = 0; n < 8; n++) begin
      preRatio = 6'(n);
      engWrite(24'h0);
      idle(8 * (n + 1) - 1);
      chk("R5 before first tick", engRdData, 24'h0);
      idle(1);
      chk("R5 first tick", engRdData, 24'h1);
      idle(8 * (n + 1) * 2 + 3);
      chk("R5 three ticks", engRdData, 24'h3);
    end
    preRatio = 6'd63;
    engWrite(24'h0);
    idle(8 * 64 * 2);
    chk("R5 max ratio", engRdData, 24'h2);

    // R7: angleInc ignored outside angle mode
    preRatio = 6'd0;
    engWrite(24'h10);
    angleInc = 1'b1; idle(5); angleInc = 1'b0;
    chk("R7 angleInc ignored in mode 01", engRdData, 24'h10);

    // R4: external clock sweep
    mode = 2'b00;
    for (int n = 0; n < 5; n++) begin
      preRatio = 6'(n);
      idle(4);
      engWrite(24'h0);
      for (int k = 0; k < 11; k++) begin
        extClk = 1'b1; idle(2);
        extClk = 1'b0; idle(2);
      end
      idle(6);
      chk("R4 ext prescaled", engRdData, 24'(11 / (n + 1)));
    end

    // R6: gated accumulation
    mode = 2'b10;
    for (int n = 0; n < 4; n++) begin
      preRatio = 6'(n);
      gateIn = 1'b0; idle(4);
      engWrite(24'h0);
      idle(8 * (n + 1) * 3);
      chk("R6 gate low holds", engRdData, 24'h0);
      gateIn = 1'b1; idle(4);
      engWrite(24'h0);
      idle(8 * (n + 1) * 3);
      chk("R6 gate high counts", engRdData, 24'h3);
    end
    gateIn = 1'b0;

    // R8: import outside angle mode, engine priority
    mode = 2'b01;
    engWrite(24'h0);
    importReq = 1'b1; importData = 24'h123456;
    @(negedge clk);
    importReq = 1'b0;
    chk("R8 import loads", engRdData, 24'h123456);
    engWrEn = 1'b1; engWrData = 24'h00BEEF;
    importReq = 1'b1; importData = 24'h777777;
    @(negedge clk);
    engWrEn = 1'b0; importReq = 1'b0;
    chk("R8 R2 engine write wins", engRdData, 24'h00BEEF);

    // R7: angle mode increments, R10 wrap
    mode = 2'b11;
    engWrite(24'h000100);
    angleInc = 1'b1; idle(5); angleInc = 1'b0;
    chk("R7 angle increments", engRdData, 24'h000105);
    idle(40);
    chk("R7 no prescaled ticks in angle", engRdData, 24'h000105);
    engWrite(24'hFFFFFF);
    angleInc = 1'b1; @(negedge clk); angleInc = 1'b0;
    chk("R10 wrap", engRdData, 24'h0);

    // R9: import refused in angle mode
    engWrite(24'h000042);
    importReq = 1'b1; importData = 24'h999999;
    idle(3);
    importReq = 1'b0;
    chk("R9 angle import ignored", engRdData, 24'h000042);
    chk("R3 host matches", hostRdData, 24'h000042);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule